// File: doc/BRIEF.md
# Big-Endian Load/Store Data Aligner

This block sits between a 32-bit integer pipeline and a word-wide data memory. On a store it copies a byte, halfword or word of the pipeline's store data onto every lane of its size. It then sets byte enables only for the lanes that the byte address selects. Byte offset 0 is the most significant lane, bits 31:24. On a load it takes the addressed byte or halfword out of the word the memory returns. It then widens the value to 32 bits, with sign extension or zero extension as the request asks.

The memory is expected to register its read data, as a block RAM does. The aligner registers the access descriptor on the request cycle. The load result and the misalignment flag are then formed combinationally from the returned word and the held descriptor, one cycle after the request. An access that is not naturally aligned is not split into parts. It is refused: the block drives no byte enables and no write strobe, and it raises a flag the following cycle.

Top module: `mem_lane_aligner`

## Requirements
- R1: `mem_addr` equals `req_addr` with its two least significant bits forced to zero, in the same cycle as the request.
- R2: A store with `req_size`=0 (byte) at offset o=`req_addr[1:0]` sets only `mem_be[3-o]`, where `mem_be[3]` covers bits 31:24. `mem_wdata` is `st_data[7:0]` repeated four times.
- R3: An aligned store with `req_size`=1 (halfword) sets `mem_be`=4'b1100 at offset 0 and 4'b0011 at offset 2. `mem_wdata` is `st_data[15:0]` repeated twice.
- R4: An aligned store with `req_size`=2 or 3 (word) sets `mem_be`=4'b1111 and passes `st_data` unchanged to `mem_wdata`.
- R5: A halfword access with `req_addr[0]`=1, or a word access with `req_addr[1:0]`≠0, drives `mem_be`=0 and `mem_we`=0 in the request cycle. `misaligned` is high in the next cycle. This applies to loads and to stores.
- R6: A valid aligned store drives `mem_we`=1. A load never drives `mem_we` or any bit of `mem_be`.
- R7: The cycle after a byte load at offset o, `ld_result` holds `rd_data[31-8o:24-8o]`. The upper 24 bits copy the byte's top bit when `req_unsigned`=0 and are zero when `req_unsigned`=1.
- R8: The cycle after a halfword load, `ld_result` holds `rd_data[31:16]` for offset 0 or `rd_data[15:0]` for offset 2. The value is sign-extended when `req_unsigned`=0 and zero-extended when it is 1.
- R9: The cycle after an aligned word load, `ld_result` equals `rd_data`.
- R10: `ld_valid` is high exactly in the cycle after a valid load request. Stores leave it low. After a misaligned load, `ld_result` is zero.
- R11: Synchronous `rst` clears the held descriptor. A request presented on a cycle with `rst` high gives `ld_valid`=0 and `misaligned`=0 in the following cycle.
- R12: With `req_valid` low, `mem_we` and `mem_be` are zero, and in the next cycle `ld_valid` and `misaligned` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_unsigned | input | 1 | Zero-extend byte or halfword loads |
| req_addr | input | 32 | Byte address |
| st_data | input | 32 | Store data, right-justified |
| rd_data | input | 32 | Word returned by memory, one cycle after the request |
| mem_addr | output | 32 | Word-aligned address to memory |
| mem_we | output | 1 | Write strobe |
| mem_be | output | 4 | Byte enables, bit 3 covers bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated write data |
| ld_valid | output | 1 | Load result valid |
| ld_result | output | 32 | Extended load value |
| misaligned | output | 1 | Previous request was not naturally aligned |

## Verification
The assertions check, on every cycle, the relations that follow from the request alone. These are address clearing, the single enable of a byte store, full enables on an aligned word store, silence of the enables on loads and on misaligned requests, the one-cycle timing of `ld_valid` and `misaligned`, and the form of the extended upper bits of a byte load. Only the bench's scenarios show that the right lane is chosen for each offset and that the replicated write data has the expected values. They also cover the exact halfword and word values that are extracted, and the clearing effect of reset on a request in flight.

// File: rtl/mla_pkg.sv
package mla_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic      vld;
    logic      store;
    logic      uns;
    acc_size_e size;
    logic      mis;
  } acc_desc_t;
endpackage

// File: rtl/mla_align_check.sv
module mla_align_check
  import mla_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] off,
  output logic             mis
);
  always_comb begin
    unique case (size)
      SZ_BYTE: mis = 1'b0;
      SZ_HALF: mis = off[0];
      default: mis = (off != '0);
    endcase
  end
endmodule

// File: rtl/mla_store_path.sv
module mla_store_path
  import mla_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  en,
  input  acc_size_e             size,
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic [DATA_W-1:0]     data,
  output logic [DATA_W/8-1:0]   be,
  output logic [DATA_W-1:0]     wdata
);
  localparam int NLANES = DATA_W / 8;
  localparam int OFF_W  = $clog2(NLANES);

  logic [DATA_W-1:0] byte_rep;
  logic [DATA_W-1:0] half_rep;

  genvar g;
  generate
    for (g = 0; g < NLANES; g++) begin : g_byte_rep
      assign byte_rep[8*g +: 8] = data[7:0];
    end
    for (g = 0; g < NLANES / 2; g++) begin : g_half_rep
      assign half_rep[16*g +: 16] = data[15:0];
    end
  endgenerate

  always_comb begin
    unique case (size)
      SZ_BYTE: wdata = byte_rep;
      SZ_HALF: wdata = half_rep;
      default: wdata = data;
    endcase
  end

  // enable bit k covers byte index NLANES-1-k (big-endian)
  always_comb begin
    be = '0;
    for (int k = 0; k < NLANES; k++) begin
      if (en) begin
        unique case (size)
          SZ_BYTE: be[k] = (OFF_W'(NLANES - 1 - k) == off);
          SZ_HALF: be[k] = (OFF_W'(NLANES - 1 - k) >> 1) == (off >> 1);
          default: be[k] = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/mla_load_path.sv
module mla_load_path
  import mla_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]           rd,
  input  acc_size_e                   size,
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic                        uns,
  input  logic                        mis,
  output logic [DATA_W-1:0]           res
);
  localparam int NLANES = DATA_W / 8;
  localparam int NHALF  = NLANES / 2;
  localparam int OFF_W  = $clog2(NLANES);

  logic [7:0]  lane_b [NLANES];
  logic [15:0] lane_h [NHALF];

  genvar g;
  generate
    for (g = 0; g < NLANES; g++) begin : g_lane_b
      assign lane_b[g] = rd[DATA_W-1-8*g -: 8];
    end
    for (g = 0; g < NHALF; g++) begin : g_lane_h
      assign lane_h[g] = rd[DATA_W-1-16*g -: 16];
    end
  endgenerate

  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  assign sel_b = lane_b[off];
  assign sel_h = lane_h[off[OFF_W-1:1]];

  always_comb begin
    if (mis) begin
      res = '0;
    end else begin
      unique case (size)
        SZ_BYTE: res = {{(DATA_W-8){~uns & sel_b[7]}}, sel_b};
        SZ_HALF: res = {{(DATA_W-16){~uns & sel_h[15]}}, sel_h};
        default: res = rd;
      endcase
    end
  end
endmodule

// File: rtl/mem_lane_aligner.sv
module mem_lane_aligner
  import mla_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_store,
  input  logic [1:0]          req_size,
  input  logic                req_unsigned,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   st_data,
  input  logic [DATA_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_we,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                ld_valid,
  output logic [DATA_W-1:0]   ld_result,
  output logic                misaligned
);
  localparam int NLANES = DATA_W / 8;
  localparam int OFF_W  = $clog2(NLANES);

  acc_size_e        size_in;
  logic [OFF_W-1:0] off_in;
  logic             mis_in;
  logic             wr_ok;

  assign size_in  = acc_size_e'(req_size);
  assign off_in   = req_addr[OFF_W-1:0];
  assign mem_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign wr_ok    = req_valid & req_store & ~mis_in;
  assign mem_we   = wr_ok;

  mla_align_check #(.OFF_W(OFF_W)) u_align (
    .size (size_in),
    .off  (off_in),
    .mis  (mis_in)
  );

  mla_store_path #(.DATA_W(DATA_W)) u_store (
    .en    (wr_ok),
    .size  (size_in),
    .off   (off_in),
    .data  (st_data),
    .be    (mem_be),
    .wdata (mem_wdata)
  );

  acc_desc_t        desc_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      desc_q <= '0;
      off_q  <= '0;
    end else begin
      desc_q.vld   <= req_valid;
      desc_q.store <= req_store;
      desc_q.uns   <= req_unsigned;
      desc_q.size  <= size_in;
      desc_q.mis   <= mis_in;
      off_q        <= off_in;
    end
  end

  logic [DATA_W-1:0] ext_val;

  mla_load_path #(.DATA_W(DATA_W)) u_load (
    .rd   (rd_data),
    .size (desc_q.size),
    .off  (off_q),
    .uns  (desc_q.uns),
    .mis  (desc_q.mis),
    .res  (ext_val)
  );

  assign ld_valid   = desc_q.vld & ~desc_q.store;
  assign misaligned = desc_q.vld & desc_q.mis;
  assign ld_result  = ld_valid ? ext_val : '0;
endmodule

// File: rtl/mla_checker.sv
module mla_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_store,
  input logic [1:0]  req_size,
  input logic        req_unsigned,
  input logic [31:0] req_addr,
  input logic [31:0] st_data,
  input logic [31:0] mem_addr,
  input logic        mem_we,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        ld_valid,
  input logic [31:0] ld_result,
  input logic        misaligned
);
  logic bad_align;
  assign bad_align = (req_size == 2'd1 && req_addr[0]) ||
                     (req_size[1] && req_addr[1:0] != 2'b00);

  // R1
  addr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    mem_addr[1:0] == 2'b00 && mem_addr[31:2] == req_addr[31:2]);

  // R2
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_store && req_size == 2'd0) |-> $countones(mem_be) == 1);

  // R4
  word_full_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_store && req_size[1] && req_addr[1:0] == 2'b00)
      |-> (mem_be == 4'hF && mem_wdata == st_data));

  // R5
  mis_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bad_align) |-> (mem_be == 4'h0 && !mem_we));

  // R5
  mis_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bad_align) |=> misaligned);

  // R6
  load_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_store) |-> (mem_be == 4'h0 && !mem_we));

  // R10
  ld_valid_next_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_store) |=> ld_valid);

  // R7
  byte_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !misaligned && $past(req_size) == 2'd0)
      |-> ld_result[31:8] == ($past(req_unsigned) ? 24'h0 : {24{ld_result[7]}}));

  // R12
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!ld_valid && !misaligned));
endmodule

bind mem_lane_aligner mla_checker u_mla_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_store    (req_store),
  .req_size     (req_size),
  .req_unsigned (req_unsigned),
  .req_addr     (req_addr),
  .st_data      (st_data),
  .mem_addr     (mem_addr),
  .mem_we       (mem_we),
  .mem_be       (mem_be),
  .mem_wdata    (mem_wdata),
  .ld_valid     (ld_valid),
  .ld_result    (ld_result),
  .misaligned   (misaligned)
);

// File: tb/mem_lane_aligner_test.sv
module mem_lane_aligner_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SD = 32'hA1B2_C3D4;
  localparam logic [31:0] RD = 32'h8A7B_6CF5;

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic        un;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] res;
    logic        mis;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 1'b0, 32'h0000_0100, 4'b1000, 32'hD4D4_D4D4, 32'h0, 1'b0},
    '{1'b1, 2'd0, 1'b0, 32'h0000_0103, 4'b0001, 32'hD4D4_D4D4, 32'h0, 1'b0},
    '{1'b1, 2'd0, 1'b0, 32'h0000_0106, 4'b0010, 32'hD4D4_D4D4, 32'h0, 1'b0},
    '{1'b1, 2'd1, 1'b0, 32'h0000_0108, 4'b1100, 32'hC3D4_C3D4, 32'h0, 1'b0},
    '{1'b1, 2'd1, 1'b0, 32'h0000_010A, 4'b0011, 32'hC3D4_C3D4, 32'h0, 1'b0},
    '{1'b1, 2'd1, 1'b0, 32'h0000_0109, 4'b0000, 32'h0,         32'h0, 1'b1},
    '{1'b1, 2'd2, 1'b0, 32'h0000_010C, 4'b1111, SD,            32'h0, 1'b0},
    '{1'b1, 2'd2, 1'b0, 32'h0000_010E, 4'b0000, 32'h0,         32'h0, 1'b1},
    '{1'b1, 2'd3, 1'b0, 32'h0000_0110, 4'b1111, SD,            32'h0, 1'b0},
    '{1'b0, 2'd0, 1'b0, 32'h0000_0200, 4'b0000, 32'h0, 32'hFFFF_FF8A, 1'b0},
    '{1'b0, 2'd0, 1'b1, 32'h0000_0200, 4'b0000, 32'h0, 32'h0000_008A, 1'b0},
    '{1'b0, 2'd0, 1'b0, 32'h0000_0201, 4'b0000, 32'h0, 32'h0000_007B, 1'b0},
    '{1'b0, 2'd0, 1'b1, 32'h0000_0202, 4'b0000, 32'h0, 32'h0000_006C, 1'b0},
    '{1'b0, 2'd0, 1'b0, 32'h0000_0203, 4'b0000, 32'h0, 32'hFFFF_FFF5, 1'b0},
    '{1'b0, 2'd1, 1'b0, 32'h0000_0204, 4'b0000, 32'h0, 32'hFFFF_8A7B, 1'b0},
    '{1'b0, 2'd1, 1'b1, 32'h0000_0204, 4'b0000, 32'h0, 32'h0000_8A7B, 1'b0},
    '{1'b0, 2'd1, 1'b0, 32'h0000_0206, 4'b0000, 32'h0, 32'h0000_6CF5, 1'b0},
    '{1'b0, 2'd2, 1'b0, 32'h0000_0208, 4'b0000, 32'h0, RD,            1'b0},
    '{1'b0, 2'd2, 1'b0, 32'h0000_0209, 4'b0000, 32'h0, 32'h0,         1'b1},
    '{1'b0, 2'd1, 1'b0, 32'h0000_0203, 4'b0000, 32'h0, 32'h0,         1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic        req_unsigned = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] st_data = '0;
  logic [31:0] rd_data = '0;
  logic [31:0] mem_addr;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        ld_valid;
  logic [31:0] ld_result;
  logic        misaligned;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_lane_aligner uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
    .st_data(st_data), .rd_data(rd_data), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .ld_valid(ld_valid),
    .ld_result(ld_result), .misaligned(misaligned)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.mis)            return "R5";
    if (!v.st)            return (v.sz == 2'd0) ? "R7" : (v.sz == 2'd1) ? "R8" : "R9";
    if (v.sz == 2'd0)     return "R2";
    if (v.sz == 2'd1)     return "R3";
    return "R4";
  endfunction

  task automatic run_vec(input vec_t v);
    string t;
    t = tag_of(v);
    @(negedge clk);
    req_valid = 1'b1; req_store = v.st; req_size = v.sz;
    req_unsigned = v.un; req_addr = v.addr; st_data = SD; rd_data = '0;
    #1;
    check("R1", "mem_addr", mem_addr, v.addr & 32'hFFFF_FFFC);
    check(t, "mem_be", {28'h0, mem_be}, {28'h0, v.be});
    check("R6", "mem_we", {31'h0, mem_we}, {31'h0, v.st & ~v.mis});
    if (v.be != 4'h0) check(t, "mem_wdata", mem_wdata, v.wd);
    @(negedge clk);
    req_valid = 1'b0; rd_data = RD;
    #1;
    check("R10", "ld_valid", {31'h0, ld_valid}, {31'h0, ~v.st});
    check("R5", "misaligned", {31'h0, misaligned}, {31'h0, v.mis});
    if (!v.st) check(v.mis ? "R10" : t, "ld_result", ld_result, v.res);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R11: state after reset
    check("R11", "ld_valid after reset", {31'h0, ld_valid}, 32'h0);
    check("R11", "misaligned after reset", {31'h0, misaligned}, 32'h0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R12: idle request lines carry a store pattern but valid is low
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b1; req_size = 2'd2; req_addr = 32'h0000_0301;
    #1;
    check("R12", "idle mem_we", {31'h0, mem_we}, 32'h0);
    check("R12", "idle mem_be", {28'h0, mem_be}, 32'h0);
    @(negedge clk);
    #1;
    check("R12", "idle ld_valid", {31'h0, ld_valid}, 32'h0);
    check("R12", "idle misaligned", {31'h0, misaligned}, 32'h0);

    // R11: misaligned load presented while reset is high is discarded
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b1; req_store = 1'b0; req_size = 2'd2;
    req_addr = 32'h0000_0402;
    @(negedge clk);
    rst = 1'b0; req_valid = 1'b0;
    #1;
    check("R11", "ld_valid after reset request", {31'h0, ld_valid}, 32'h0);
    check("R11", "misaligned after reset request", {31'h0, misaligned}, 32'h0);

    // R10: back-to-back load then store
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b0; req_size = 2'd2; req_addr = 32'h0000_0500;
    @(negedge clk);
    req_store = 1'b1; rd_data = RD;
    #1;
    check("R10", "ld_valid after load", {31'h0, ld_valid}, 32'h1);
    check("R9", "ld_result back-to-back", ld_result, RD);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check("R10", "ld_valid after store", {31'h0, ld_valid}, 32'h0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule